// File: doc/BRIEF.md
# Bus-Mode Configuration Frame Generator

This block produces one of two fixed eight-byte frames for a downstream SPI byte shifter. The first kind is a wake-up frame of all-ones bytes. The second kind is a configuration frame that switches an attached peripheral into its 32-bit word transfer mode. One start pulse launches a frame. A select input picks which frame is sent, and a 3-bit setting gives the number of fixed busy words the peripheral should insert before read data.

For a configuration frame, the block first spends five cycles on a 7-bit checksum. It processes one frame byte per cycle, in a fixed permuted order. It then presents the eight bytes one per cycle, with a valid strobe and a done flag on the last byte. The checksum is placed in byte 4 with an end bit. A wake-up frame skips the checksum phase.

Top module: `initfrm_gen`

## Requirements
- R1: When started with `frameSel`=0, the block emits eight bytes, all 0xFF. The first byte is valid in the cycle after the clock edge that samples the start pulse.
- R2: When started with `frameSel`=1, the fixed bytes of the configuration frame are: index 0 = 0x00, index 1 = 0x40, index 2 = 0xFF, index 3 = 0xFF, index 7 = 0x00.
- R3: Byte index 6 holds the busy-length setting in bits 2:0. Bits 7:3 of that byte are zero.
- R4: Byte index 5 is 0x79 when the busy-length setting is zero. It is 0xF9 otherwise, so bit 7 is set exactly when the setting is nonzero.
- R5: Byte index 4 is the 7-bit checksum in bits 7:1, with bit 0 set to 1. The checksum uses generator x^7+x^3+1, starts from zero, and runs MSB first over bytes 1, 0, 7, 6, 5 in that order.
- R6: A configuration frame spends five cycles on the checksum. Its first byte is valid six cycles after the start edge. All eight bytes then follow in index order 0..7, one per cycle, with `outValid` high without a gap.
- R7: `outDone` is high only in the cycle that carries byte index 7, and for a single cycle.
- R8: A start pulse is ignored while a frame is in progress, including during the checksum phase and during the last byte. `frameSel` and `busyLen` are sampled only when a start is accepted. A start in the cycle right after the last byte is accepted.
- R9: After reset, and whenever no byte is presented, `outValid`, `outDone` and `outData` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| startPulse | input | 1 | Launches a frame when the block is idle |
| frameSel | input | 1 | 0 selects the all-ones frame, 1 the configuration frame |
| busyLen | input | 3 | Fixed busy-word count carried in the configuration frame |
| outData | output | 8 | Byte for the shifter, sent MSB first by the shifter |
| outValid | output | 1 | outData holds a frame byte |
| outDone | output | 1 | Current byte is the last of the frame |

## Verification
Two functions can meet in the same cycle: presenting the final byte of a frame, and accepting a new start. The bench raises a start during the last byte, with a different frame select, and holds it into the next cycle. The first cycle must be ignored and the second must launch a fresh frame with no idle gap. A start is also raised during the checksum phase, together with a changed busy length. The bench checks that neither the running frame's bytes nor its checksum move. A behavioural model predicts every output on every cycle, and each cycle is compared against it.

// File: rtl/initfrm_pkg.sv
package initfrm_pkg;
  localparam int FRAME_BYTES = 8;
  localparam int IDX_W = $clog2(FRAME_BYTES);
  localparam int CRC_W = 7;
  localparam int CRC_SPAN = 5;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CRC,
    ST_SEND
  } state_t;

  typedef struct packed {
    logic             capture;
    logic             crcStep;
    logic [IDX_W-1:0] crcSel;
    logic             emit;
    logic [IDX_W-1:0] byteSel;
    logic             last;
  } strobe_t;
endpackage

// File: rtl/initfrm_control.sv
module initfrm_control
  import initfrm_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startPulse,
  input  logic    frameSel,
  output strobe_t strb
);
  state_t           state;
  logic [IDX_W-1:0] cnt;
  logic             lastByte;
  logic             lastCrc;

  assign lastByte = (state == ST_SEND) && (cnt == IDX_W'(FRAME_BYTES - 1));
  assign lastCrc  = (state == ST_CRC) && (cnt == IDX_W'(CRC_SPAN - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (startPulse) begin
          state <= frameSel ? ST_CRC : ST_SEND;
          cnt   <= '0;
        end
        ST_CRC: begin
          if (lastCrc) begin
            state <= ST_SEND;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SEND: begin
          if (lastByte) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // checksum walks the frame in a fixed permuted order
  always_comb begin
    strb         = '0;
    strb.capture = (state == ST_IDLE) && startPulse;
    strb.crcStep = (state == ST_CRC);
    case (cnt)
      IDX_W'(0): strb.crcSel = IDX_W'(1);
      IDX_W'(1): strb.crcSel = IDX_W'(0);
      IDX_W'(2): strb.crcSel = IDX_W'(7);
      IDX_W'(3): strb.crcSel = IDX_W'(6);
      default:   strb.crcSel = IDX_W'(5);
    endcase
    strb.emit    = (state == ST_SEND);
    strb.byteSel = cnt;
    strb.last    = lastByte;
  end

  p_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SEND && !lastByte) |=> (state == ST_SEND && cnt == $past(cnt) + 1'b1));

  p_crc_len_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SEND && $past(state) == ST_CRC) |-> ($past(cnt) == IDX_W'(CRC_SPAN - 1)));

  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && !lastByte) |=> (state != ST_IDLE));
endmodule

// File: rtl/initfrm_datapath.sv
module initfrm_datapath
  import initfrm_pkg::*;
#(
  parameter int BUSY_W = 3,
  parameter logic [CRC_W-1:0] CRC_POLY = 7'h09
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              frameSel,
  input  logic [BUSY_W-1:0] busyLen,
  output logic [7:0]        outData
);
  logic [BUSY_W-1:0] lenReg;
  logic              isInit;
  logic [CRC_W-1:0]  crcReg;
  logic [7:0]        frameByte [FRAME_BYTES];

  function automatic logic [CRC_W-1:0] crcByte(logic [CRC_W-1:0] c, logic [7:0] d);
    logic [CRC_W-1:0] r;
    logic fb;
    r = c;
    for (int b = 7; b >= 0; b--) begin
      fb = r[CRC_W-1] ^ d[b];
      r  = {r[CRC_W-2:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenReg <= '0;
      isInit <= 1'b0;
      crcReg <= '0;
    end else if (strb.capture) begin
      lenReg <= busyLen;
      isInit <= frameSel;
      crcReg <= '0;
    end else if (strb.crcStep) begin
      crcReg <= crcByte(crcReg, frameByte[strb.crcSel]);
    end
  end

  always_comb begin
    for (int i = 0; i < FRAME_BYTES; i++) frameByte[i] = isInit ? 8'h00 : 8'hFF;
    if (isInit) begin
      frameByte[1] = 8'h40;
      frameByte[2] = 8'hFF;
      frameByte[3] = 8'hFF;
      frameByte[4] = {crcReg, 1'b1};
      frameByte[5] = {(lenReg != '0), 7'h79};
      frameByte[6] = 8'(lenReg);
    end
  end

  assign outData = strb.emit ? frameByte[strb.byteSel] : 8'h00;

  p_len_held_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.emit && !strb.last) |=> $stable(lenReg) && $stable(crcReg));
endmodule

// File: rtl/initfrm_gen.sv
module initfrm_gen
  import initfrm_pkg::*;
#(
  parameter int BUSY_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic              frameSel,
  input  logic [BUSY_W-1:0] busyLen,
  output logic [7:0]        outData,
  output logic              outValid,
  output logic              outDone
);
  strobe_t strb;

  initfrm_control i_control (
    .clk(clk), .rstN(rstN), .startPulse(startPulse),
    .frameSel(frameSel), .strb(strb)
  );

  initfrm_datapath #(.BUSY_W(BUSY_W)) i_datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .frameSel(frameSel),
    .busyLen(busyLen), .outData(outData)
  );

  assign outValid = strb.emit;
  assign outDone  = strb.last;

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    outDone |=> !outDone);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (outData == 8'h00 && !outDone));
endmodule

// File: tb/test_initfrm_gen.sv
module test_initfrm_gen;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startPulse = 1'b0;
  logic       frameSel = 1'b0;
  logic [2:0] busyLen = 3'd0;
  logic [7:0] outData;
  logic       outValid;
  logic       outDone;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    logic       v;
    logic [7:0] d;
    logic       dn;
    string      req;
  } exp_t;
  exp_t q[$];

  always #(CLK_P/2) clk = ~clk;

  initfrm_gen i_initfrm_gen (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .frameSel(frameSel),
    .busyLen(busyLen), .outData(outData), .outValid(outValid), .outDone(outDone)
  );

  function automatic int crcCalc(int seq[5]);
    int c = 0;
    for (int k = 0; k < 5; k++) begin
      for (int b = 7; b >= 0; b--) begin
        c = (c << 1) | 0;
        if ((((c >> 7) & 1) ^ ((seq[k] >> b) & 1)) != 0) c = c ^ 9;
        c = c & 8'h7F;
      end
    end
    return c;
  endfunction

  task automatic planFrame(logic sel, logic [2:0] len);
    int fr[8];
    int seq[5];
    exp_t e;
    if (!sel) begin
      for (int i = 0; i < 8; i++) fr[i] = 8'hFF;
    end else begin
      fr[0] = 0; fr[1] = 8'h40; fr[2] = 8'hFF; fr[3] = 8'hFF; fr[7] = 0;
      fr[6] = int'(len);
      fr[5] = (len != 0) ? 8'hF9 : 8'h79;
      seq[0] = fr[1]; seq[1] = fr[0]; seq[2] = fr[7]; seq[3] = fr[6]; seq[4] = fr[5];
      fr[4] = (crcCalc(seq) << 1) | 1;
      for (int i = 0; i < 5; i++) begin
        e.v = 0; e.d = 0; e.dn = 0; e.req = "R6 checksum phase";
        q.push_back(e);
      end
    end
    for (int i = 0; i < 8; i++) begin
      e.v = 1; e.d = 8'(fr[i]); e.dn = (i == 7);
      if (!sel) e.req = "R1 all-ones byte";
      else if (i == 4) e.req = "R5 checksum byte";
      else if (i == 5) e.req = "R4 flags byte";
      else if (i == 6) e.req = "R3 busy byte";
      else e.req = "R2 fixed byte";
      if (i == 7) e.req = {e.req, " / R7 done"};
      q.push_back(e);
    end
  endtask

  // reference model and comparison, sampled at the falling edge
  always @(negedge clk) begin
    exp_t e;
    bit wasBusy;
    if (rstN && !finished) begin
      wasBusy = (q.size() > 0);
      if (wasBusy) e = q.pop_front();
      else begin e.v = 0; e.d = 0; e.dn = 0; e.req = "R8/R9 idle"; end
      total++;
      if (outValid !== e.v || outData !== e.d || outDone !== e.dn) begin
        bad++;
        $display("FAIL %s: got v=%0b d=%02h done=%0b, expected v=%0b d=%02h done=%0b",
                 e.req, outValid, outData, outDone, e.v, e.d, e.dn);
      end
      if (startPulse && !wasBusy) planFrame(frameSel, busyLen);
    end
  end

  task automatic pulse(logic sel, logic [2:0] len);
    @(posedge clk); #1;
    startPulse = 1; frameSel = sel; busyLen = len;
    @(posedge clk); #1;
    startPulse = 0;
  endtask

  task automatic drain();
    while (q.size() > 0) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    #(CLK_P * 100000);
    bad++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    total++;
    if (outValid !== 0 || outDone !== 0 || outData !== 8'h00) begin
      bad++;
      $display("FAIL R9 reset: got v=%0b d=%02h done=%0b, expected 0 00 0",
               outValid, outData, outDone);
    end

    pulse(0, 3'd5);                 // R1
    drain();
    pulse(1, 3'd0);                 // R2 R4 R5 zero length
    drain();
    pulse(1, 3'd1);                 // R3 R4
    drain();
    pulse(1, 3'd3);
    drain();
    pulse(1, 3'd7);                 // R3 full range
    drain();

    // R8: start during the checksum phase with other settings
    pulse(1, 3'd2);
    @(posedge clk); #1;
    startPulse = 1; frameSel = 0; busyLen = 3'd6;
    @(posedge clk); #1;
    startPulse = 0;
    drain();

    // R8: start during last byte ignored, held one more cycle and accepted
    pulse(0, 3'd0);
    repeat (7) @(posedge clk);
    #1 startPulse = 1; frameSel = 1; busyLen = 3'd4;
    @(posedge clk); #1;
    frameSel = 0;
    @(posedge clk); #1;
    startPulse = 0;
    drain();

    // R6 back-to-back configuration frames
    pulse(1, 3'd5);
    while (q.size() > 1) @(posedge clk);
    #1 startPulse = 1; frameSel = 1; busyLen = 3'd6;
    @(posedge clk); #1;
    @(posedge clk); #1;
    startPulse = 0;
    drain();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule